// File: doc/BRIEF.md
# Fractional Baud Rate Tick Generator

This block derives the timing enables for an asynchronous serial port from a single peripheral clock. A 16-bit integer divisor, built from a low byte and a high byte, sets the base period of a sample tick. A fractional pre-scaler can stretch that period on average by a factor of 1 + ADD/MUL. It does this by doubling selected divisor periods, under the control of a small phase accumulator. A programmable oversampling count groups sample ticks into bit periods. The resulting rate is clk / ((OVS+1) × D × (1 + ADD/MUL)).

Software configures the block through a byte-wide write port and reads the same fields back through a combinational read port. Any write restarts the tick phase from a clean state, so a new configuration takes effect at a predictable time. The two outputs are single-cycle, active-high enables that are synchronous to `clk`. The serializer and the deserializer of the port consume them.

Top module: `fracbaud_tick`

## Requirements
- R1: After a synchronous reset, readback gives divisor low = 0x01, divisor high = 0x00, fractional field = 0x10 (ADD = 0, MUL = 1) and oversampling field = 0x0F. Both ticks are low in the first cycle after reset.
- R2: Register addresses: 0 is the divisor low byte, 1 is the divisor high byte, 2 is the fractional field (ADD in bits 3:0, MUL in bits 7:4), 3 is the oversampling field. `rdData` shows the register selected by `rdAddr`, combinationally, with the last value written.
- R3: With divisor D = 256·high + low and the fraction inactive, `sampleTick` is a one-cycle pulse. The first pulse comes D rising edges after a reload edge, and the pulses then repeat every D edges.
- R4: A divisor of 0 behaves exactly as a divisor of 1, so a sample tick occurs on every cycle.
- R5: With a valid fraction, each sample tick adds ADD to an accumulator that is cleared at reload. When the sum reaches MUL or more, MUL is subtracted and the gap to the next tick is 2·D edges instead of D edges.
- R6: The fraction is bypassed, with all gaps equal to D, when ADD = 0, when MUL = 0 or when ADD ≥ MUL.
- R7: `bitTick` pulses once per (field+1) sample ticks, always in the same cycle as the last sample tick of the group. A field of 0 makes every sample tick a bit tick.
- R8: Any write restarts the phase. In the cycle after the write edge both ticks are low, the divisor, accumulator and oversampling counts start from zero, and timing then follows R3 to R7 from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register select |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read register select |
| rdData | output | 8 | Readback of the selected register |
| sampleTick | output | 1 | One-cycle oversampling enable |
| bitTick | output | 1 | One-cycle bit-period enable, coincident with the last sample tick |

## Verification
The hardest case to reach from the ports is an accumulator overflow that lands exactly on the sample tick that also closes an oversampling group. A write that restarts the phase while a stretched period is pending is equally hard to reach. The stimulus uses small divisors together with fractions such as 3/5 and 1/2 and short oversampling groups, so that overflows, group ends and stretch periods coincide often within a few hundred cycles. It also issues writes a few cycles into a period to cut a pending stretch. A behavioural gap-countdown model in the bench predicts both ticks on every clock.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;
  localparam int ADR_DIV_LO = 0;
  localparam int ADR_DIV_HI = 1;
  localparam int ADR_FRAC   = 2;
  localparam int ADR_OVS    = 3;
  localparam int NUM_REGS   = 4;

  typedef struct packed {
    logic reload;
    logic step;
  } strobes_t;

  typedef struct packed {
    logic divTerm;
    logic accOver;
    logic ovsTerm;
  } flags_t;
endpackage

// File: rtl/fracbaud_data.sv
module fracbaud_data
  import fracbaud_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  strobes_t          strb,
  output flags_t            flg
);
  localparam int DIV_W = 2 * REG_W;
  localparam int NIB_W = REG_W / 2;
  localparam int ACC_W = NIB_W + 1;

  function automatic logic [REG_W-1:0] rstVal(input int idx);
    case (idx)
      ADR_DIV_LO: rstVal = REG_W'(1);
      ADR_FRAC:   rstVal = REG_W'(1) << NIB_W;
      ADR_OVS:    rstVal = REG_W'(15);
      default:    rstVal = '0;
    endcase
  endfunction

  logic [REG_W-1:0] regFile [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regFile[i] <= rstVal(i);
      else if (wrEn && (wrAddr == ADDR_W'(i)))
        regFile[i] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) rdData = regFile[i];
  end

  // integer divisor
  logic [DIV_W-1:0] divisor, divEff, divCnt;
  assign divisor = {regFile[ADR_DIV_HI], regFile[ADR_DIV_LO]};
  assign divEff  = (divisor == '0) ? DIV_W'(1) : divisor;
  assign flg.divTerm = (divCnt == divEff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || strb.reload || flg.divTerm) divCnt <= '0;
    else                                  divCnt <= divCnt + DIV_W'(1);
  end

  // fractional phase accumulator
  logic [NIB_W-1:0] addVal, mulVal, addEff, acc;
  logic [ACC_W-1:0] accSum;
  logic             fracOn;
  assign addVal = regFile[ADR_FRAC][NIB_W-1:0];
  assign mulVal = regFile[ADR_FRAC][REG_W-1:NIB_W];
  assign fracOn = (mulVal != '0) && (addVal < mulVal);
  assign addEff = fracOn ? addVal : '0;
  assign accSum = ACC_W'(acc) + ACC_W'(addEff);
  assign flg.accOver = (addEff != '0) && (accSum >= ACC_W'(mulVal));

  always_ff @(posedge clk) begin
    if (rst || strb.reload)
      acc <= '0;
    else if (strb.step)
      acc <= flg.accOver ? NIB_W'(accSum - ACC_W'(mulVal)) : NIB_W'(accSum);
  end

  // oversampling group counter
  logic [REG_W-1:0] ovsCnt;
  assign flg.ovsTerm = (ovsCnt == regFile[ADR_OVS]);

  always_ff @(posedge clk) begin
    if (rst || strb.reload)
      ovsCnt <= '0;
    else if (strb.step)
      ovsCnt <= flg.ovsTerm ? '0 : ovsCnt + REG_W'(1);
  end
endmodule

// File: rtl/fracbaud_ctrl.sv
module fracbaud_ctrl
  import fracbaud_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wrEn,
  input  flags_t   flg,
  output strobes_t strb,
  output logic     sampleTick,
  output logic     bitTick
);
  logic stretch;

  assign strb.reload = wrEn;
  assign strb.step   = flg.divTerm && !stretch && !wrEn;

  always_ff @(posedge clk) begin
    if (rst || wrEn)
      stretch <= 1'b0;
    else if (flg.divTerm)
      stretch <= stretch ? 1'b0 : flg.accOver;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else begin
      sampleTick <= strb.step;
      bitTick    <= strb.step && flg.ovsTerm;
    end
  end
endmodule

// File: rtl/fracbaud_tick.sv
module fracbaud_tick
  import fracbaud_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              sampleTick,
  output logic              bitTick
);
  strobes_t strb;
  flags_t   flg;

  fracbaud_data #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strb(strb), .flg(flg)
  );

  fracbaud_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .flg(flg), .strb(strb),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );
endmodule

// File: rtl/fracbaud_chk.sv
module fracbaud_chk #(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [REG_W-1:0]  rdData,
  input logic              sampleTick,
  input logic              bitTick
);
  p_bit_in_sample_r7: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> sampleTick);

  p_write_quiets_sample_r8: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !sampleTick);

  p_write_quiets_bit_r8: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !bitTick);

  p_readback_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(wrEn) && $stable(rdAddr)) |-> $stable(rdData));

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sampleTick && !bitTick));
endmodule

bind fracbaud_tick fracbaud_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fracbaud_tick_bench.sv
module fracbaud_tick_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       sampleTick, bitTick;

  int total = 0, bad = 0, cycles = 0;
  string curReq = "R1";

  fracbaud_tick u_fracbaud_tick (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sampleTick(sampleTick), .bitTick(bitTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: register shadow plus countdown to the next tick
  int regM [4];
  int toGo, accM, sampCnt;
  bit expS, expB;

  function automatic int effDiv();
    int d = regM[1] * 256 + regM[0];
    return (d == 0) ? 1 : d;
  endfunction
  function automatic int mulOf();
    return regM[2] / 16;
  endfunction
  function automatic int effAdd();
    int a = regM[2] % 16;
    int m = regM[2] / 16;
    return (m == 0 || a >= m) ? 0 : a;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst || wrEn) begin
      if (rst) begin
        regM[0] = 1; regM[1] = 0; regM[2] = 16; regM[3] = 15;
      end else begin
        regM[wrAddr] = wrData;
      end
      toGo = effDiv(); accM = 0; sampCnt = 0; expS = 0; expB = 0;
    end else begin
      toGo--; expS = 0; expB = 0;
      if (toGo == 0) begin
        int a;
        expS = 1;
        sampCnt++;
        if (sampCnt == regM[3] + 1) begin expB = 1; sampCnt = 0; end
        a = effAdd();
        accM += a;
        toGo = effDiv();
        if (a != 0 && accM >= mulOf()) begin
          accM -= mulOf();
          toGo = 2 * effDiv();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (sampleTick !== expS) begin
        bad++;
        $display("FAIL %s sampleTick actual=%b expected=%b at cycle %0d", curReq, sampleTick, expS, cycles);
      end
      total++;
      if (bitTick !== expB) begin
        bad++;
        $display("FAIL %s bitTick actual=%b expected=%b at cycle %0d", curReq, bitTick, expB, cycles);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); #1;
    rdAddr = a;
    #1;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s readback addr %0d actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1: reset values and default ticking
    curReq = "R1";
    rdCheck(2'd0, 8'h01, "R1");
    rdCheck(2'd1, 8'h00, "R1");
    rdCheck(2'd2, 8'h10, "R1");
    rdCheck(2'd3, 8'h0F, "R1");
    run(40);
    // R3 and R2: integer divisor, readback of written fields
    curReq = "R3";
    wr(2'd0, 8'd3);
    wr(2'd3, 8'd3);
    run(60);
    rdCheck(2'd0, 8'd3, "R2");
    rdCheck(2'd3, 8'd3, "R2");
    // R4: zero divisor acts as one
    curReq = "R4";
    wr(2'd0, 8'd0);
    run(20);
    // R5: fractions
    curReq = "R5";
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h21);
    run(100);
    rdCheck(2'd2, 8'h21, "R2");
    wr(2'd0, 8'd1);
    wr(2'd2, 8'h53);
    run(100);
    wr(2'd2, 8'hF7);
    wr(2'd3, 8'd2);
    run(150);
    // R5 with a wide divisor using the high byte
    wr(2'd1, 8'd1);
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h21);
    wr(2'd3, 8'd0);
    rdCheck(2'd1, 8'd1, "R2");
    run(1300);
    wr(2'd1, 8'd0);
    // R6: bypass cases
    curReq = "R6";
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h55);
    run(50);
    wr(2'd2, 8'h03);
    run(50);
    wr(2'd2, 8'h40);
    run(50);
    wr(2'd2, 8'h4E);
    run(50);
    // R7: oversampling group lengths
    curReq = "R7";
    wr(2'd2, 8'h10);
    wr(2'd0, 8'd1);
    wr(2'd3, 8'd0);
    run(20);
    wr(2'd3, 8'd2);
    run(40);
    wr(2'd0, 8'd3);
    wr(2'd2, 8'h32);
    run(120);
    // R8: writes mid-period, including cutting a pending stretch
    curReq = "R8";
    wr(2'd0, 8'd10);
    run(4);
    wr(2'd0, 8'd10);
    run(30);
    wr(2'd0, 8'd4);
    wr(2'd2, 8'h21);
    run(6);
    wr(2'd3, 8'd2);
    run(5);
    wr(2'd2, 8'h21);
    run(80);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule